// File: doc/BRIEF.md
# Tagged Shared Refill FIFO

This block is a short first-in first-out queue that sits between a memory response path and a group of caches of the same kind. Each stored entry holds one refill word and the number of the cache that should receive it. The response side pushes a word together with that cache number. It may push only while the block raises its acknowledge, and the acknowledge depends only on how many entries are stored.

On the cache side, every cache watches the same head entry. A cache sees its valid bit only when the queue holds something and the head is addressed to it. Every cache sees the head word on the shared data output. A cache removes the head by raising its own pop line. A pop line from a cache that does not own the head is ignored, and so is a pop while the queue is empty.

Top module: `tagged_refill_fifo`

## Requirements
- R1: Entries leave in the order they were accepted, and each keeps the data word and cache number it was pushed with.
- R2: `cons_valid[x]` is 1 exactly when the queue is non-empty and the head entry's cache number equals x. At most one bit is ever set.
- R3: While any `cons_valid` bit is set, `cons_data` equals the data word of the head entry.
- R4: `push_ack` is 1 exactly while fewer than ACK_LEVEL entries are stored. The default ACK_LEVEL is 2.
- R5: An entry is stored only when `push_valid` and `push_ack` are both 1. A push offered while `push_ack` is 0 leaves the contents unchanged.
- R6: When the owner of the head raises its `cons_pop` bit, the head is removed at that clock edge, and the next entry (if any) appears in the following cycle.
- R7: A `cons_pop` bit raised by a cache that does not own the head has no effect.
- R8: A pop while the queue is empty has no effect. In particular, the entry count does not wrap.
- R9: A push and a pop accepted at the same edge leave the number of stored entries unchanged.
- R10: While `rst_n` is 0 at a rising clock edge, all entries are dropped. After reset, `push_ack` is 1 and all `cons_valid` bits are 0.
- R11: A word accepted at a rising edge is visible at the consumer outputs in the cycle that follows that edge, if it is then at the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_valid | input | 1 | The response side offers a word |
| push_data | input | DATA_W | Refill word offered |
| push_tag | input | TAG_W | Number of the destination cache |
| push_ack | output | 1 | Room is available; depends only on occupancy |
| cons_valid | output | NUM_CACHES | Per-cache valid: the head belongs to that cache |
| cons_data | output | DATA_W | Data word of the head entry |
| cons_pop | input | NUM_CACHES | Per-cache request to remove the head |

## Verification
`push_ack`, `cons_valid` and `cons_data` are combinational functions of the stored state. Every accepted push or pop therefore shows at the outputs in the cycle after the edge that accepted it, with no extra delay. The bench drives inputs at the falling edge and compares the outputs 1 ns later, still before the next rising edge, against a queue model in the bench. It then applies the accept rules to that model at the same edge the design uses. As a result, each expected value belongs to exactly one cycle and is never sampled across a state change.

// File: rtl/refill_fifo_pkg.sv
// Package: refill_fifo_pkg
// Holds the default sizing shared by the FIFO modules and the bench.
// Assumes at least two caches, so that a cache number needs at least one bit.
package refill_fifo_pkg;
    localparam int DEF_DATA_W     = 32;
    localparam int DEF_NUM_CACHES = 4;
    localparam int DEF_DEPTH      = 2;
    localparam int DEF_ACK_LEVEL  = 2;
endpackage

// File: rtl/refill_store.sv
// Module: refill_store
// Circular storage for tagged refill entries, with a read pointer, a write pointer and an occupancy count.
// Assumes push_fire and pop_fire are already qualified by the caller:
// no push when full, no pop when empty.
module refill_store #(
    parameter int DATA_W    = refill_fifo_pkg::DEF_DATA_W,
    parameter int TAG_W     = 2,
    parameter int DEPTH     = refill_fifo_pkg::DEF_DEPTH,
    parameter int ACK_LEVEL = refill_fifo_pkg::DEF_ACK_LEVEL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_fire,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              pop_fire,
    output logic [DATA_W-1:0] head_data,
    output logic [TAG_W-1:0]  head_tag,
    output logic              nonempty,
    output logic              room
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ACK_CNT  = CNT_W'(ACK_LEVEL);

    logic [DATA_W-1:0] data_q [DEPTH];
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;

    // Write the incoming entry into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push_fire) begin
            data_q[wr_ptr] <= wr_data;
            tag_q[wr_ptr]  <= wr_tag;
        end
    end

    // Advance the pointers and the count; reset drops every entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_fire)
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (pop_fire)
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            case ({push_fire, pop_fire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Present the head entry and the occupancy flags.
    always_comb begin
        head_data = data_q[rd_ptr];
        head_tag  = tag_q[rd_ptr];
        nonempty  = (count != '0);
        room      = (count < ACK_CNT);
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_refused_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!room && !pop_fire) |=> count == $past(count));
    assert_pop_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_fire && !push_fire) |=> count == $past(count) - 1'b1);
    assert_idle_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!nonempty && !push_fire) |=> !nonempty);
    assert_push_pop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_fire && pop_fire) |=> count == $past(count));
endmodule

// File: rtl/refill_head_route.sv
// Module: refill_head_route
// Decodes the head's cache number into per-cache valid bits and keeps only the pop from the head's owner.
// Assumes head_tag is meaningful only while nonempty is high.
module refill_head_route #(
    parameter int NUM_CACHES = refill_fifo_pkg::DEF_NUM_CACHES,
    parameter int TAG_W      = 2
) (
    input  logic                  nonempty,
    input  logic [TAG_W-1:0]      head_tag,
    input  logic [NUM_CACHES-1:0] cons_pop,
    output logic [NUM_CACHES-1:0] cons_valid,
    output logic                  pop_fire
);
    for (genvar gi = 0; gi < NUM_CACHES; gi++) begin : g_owner
        // Raise valid for this cache only when it owns the head.
        always_comb cons_valid[gi] = nonempty && (head_tag == TAG_W'(gi));
    end

    // Accept a pop only from the cache currently shown valid.
    always_comb pop_fire = |(cons_valid & cons_pop);
endmodule

// File: rtl/tagged_refill_fifo.sv
// Module: tagged_refill_fifo
// A refill FIFO shared by several caches. Entries carry a cache number, and each cache sees valid only for head entries tagged with its own number.
// Assumes the response side holds push_valid, push_data and push_tag steady until push_ack accepts them.
module tagged_refill_fifo #(
    parameter int DATA_W     = refill_fifo_pkg::DEF_DATA_W,
    parameter int NUM_CACHES = refill_fifo_pkg::DEF_NUM_CACHES,
    parameter int DEPTH      = refill_fifo_pkg::DEF_DEPTH,
    parameter int ACK_LEVEL  = refill_fifo_pkg::DEF_ACK_LEVEL,
    localparam int TAG_W     = $clog2(NUM_CACHES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_valid,
    input  logic [DATA_W-1:0]     push_data,
    input  logic [TAG_W-1:0]      push_tag,
    output logic                  push_ack,
    output logic [NUM_CACHES-1:0] cons_valid,
    output logic [DATA_W-1:0]     cons_data,
    input  logic [NUM_CACHES-1:0] cons_pop
);
    logic              push_fire;
    logic              pop_fire;
    logic              nonempty;
    logic              room;
    logic [TAG_W-1:0]  head_tag;
    logic [DATA_W-1:0] head_data;

    // Accept a push only when the occupancy leaves room.
    always_comb begin
        push_ack  = room;
        push_fire = push_valid && room;
        cons_data = head_data;
    end

    refill_store #(
        .DATA_W(DATA_W), .TAG_W(TAG_W), .DEPTH(DEPTH), .ACK_LEVEL(ACK_LEVEL)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .push_fire(push_fire), .wr_data(push_data), .wr_tag(push_tag),
        .pop_fire(pop_fire),
        .head_data(head_data), .head_tag(head_tag),
        .nonempty(nonempty), .room(room)
    );

    refill_head_route #(
        .NUM_CACHES(NUM_CACHES), .TAG_W(TAG_W)
    ) u_route (
        .nonempty(nonempty), .head_tag(head_tag), .cons_pop(cons_pop),
        .cons_valid(cons_valid), .pop_fire(pop_fire)
    );

    assert_single_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cons_valid));
    assert_pop_needs_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_pop & cons_valid) == '0 |-> !pop_fire);
    assert_valid_after_push_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_fire && !nonempty) |=> (cons_valid != '0));
endmodule

// File: tb/sim_tagged_refill_fifo.sv
module sim_tagged_refill_fifo;
    localparam int DW = 32;
    localparam int NC = 4;
    localparam int TW = 2;
    localparam int ACK_LVL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_valid = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic [TW-1:0] push_tag = '0;
    logic          push_ack;
    logic [NC-1:0] cons_valid;
    logic [DW-1:0] cons_data;
    logic [NC-1:0] cons_pop = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [DW-1:0] m_data[$];
    logic [TW-1:0] m_tag[$];

    always #2 clk = ~clk;

    tagged_refill_fifo u0 (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_data(push_data), .push_tag(push_tag),
        .push_ack(push_ack), .cons_valid(cons_valid), .cons_data(cons_data),
        .cons_pop(cons_pop)
    );

    function automatic logic exp_ack();
        return m_data.size() < ACK_LVL;
    endfunction

    function automatic logic [NC-1:0] exp_valid();
        if (m_data.size() == 0) return '0;
        return NC'(1) << m_tag[0];
    endfunction

    // Compare outputs with the model, then apply one edge of stimulus to both.
    task automatic step(input logic pv, input logic [TW-1:0] pt, input logic [DW-1:0] pd,
                        input logic [NC-1:0] pop, input string req);
        logic do_pop, do_push;
        @(negedge clk);
        push_valid = pv; push_tag = pt; push_data = pd; cons_pop = pop;
        #1;
        n_tests++;
        if (push_ack !== exp_ack()) begin
            n_fail++;
            $display("FAIL %s/R4 push_ack actual %0b expected %0b", req, push_ack, exp_ack());
        end
        n_tests++;
        if (cons_valid !== exp_valid()) begin
            n_fail++;
            $display("FAIL %s/R2 cons_valid actual %b expected %b", req, cons_valid, exp_valid());
        end
        if (m_data.size() > 0) begin
            n_tests++;
            if (cons_data !== m_data[0]) begin
                n_fail++;
                $display("FAIL %s/R3 cons_data actual %h expected %h", req, cons_data, m_data[0]);
            end
        end
        do_pop  = (m_data.size() > 0) && pop[m_tag[0]];
        do_push = pv && (m_data.size() < ACK_LVL);
        if (do_pop) begin
            void'(m_data.pop_front());
            void'(m_tag.pop_front());
        end
        if (do_push) begin
            m_data.push_back(pd);
            m_tag.push_back(pt);
        end
        @(posedge clk);
    endtask

    // Hold reset for two edges, then release it; the model empties as well.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; push_valid = 1'b0; cons_pop = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_data.delete();
        m_tag.delete();
        #1;
        n_tests++;
        if (push_ack !== 1'b1 || cons_valid !== '0) begin
            n_fail++;
            $display("FAIL R10 after reset ack/valid actual %0b/%b expected 1/0000", push_ack, cons_valid);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual running expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0417));
        do_reset();                                               // R10 reset state
        // R11: a pushed word shows at the next cycle for cache 2.
        step(1'b1, 2'd2, 32'hAAAA_0001, 4'b0000, "R11");
        // R7: a pop from cache 0, which does not own the head, is ignored.
        step(1'b0, 2'd0, 32'h0, 4'b0001, "R7");
        step(1'b0, 2'd0, 32'h0, 4'b1011, "R7");
        // R6: the owner pops the head.
        step(1'b0, 2'd0, 32'h0, 4'b0100, "R6");
        // R8: pops while empty must not wrap the count.
        step(1'b0, 2'd0, 32'h0, 4'b1111, "R8");
        step(1'b1, 2'd1, 32'hBBBB_0002, 4'b1111, "R8");
        step(1'b0, 2'd0, 32'h0, 4'b0000, "R8");
        step(1'b0, 2'd0, 32'h0, 4'b0010, "R8");
        // R1 and R5: fill to two entries, push while refused, then drain in order.
        step(1'b1, 2'd3, 32'hCCCC_0003, 4'b0000, "R1");
        step(1'b1, 2'd0, 32'hDDDD_0004, 4'b0000, "R1");
        step(1'b1, 2'd1, 32'hEEEE_0005, 4'b0000, "R5");
        step(1'b0, 2'd0, 32'h0, 4'b1000, "R1");
        step(1'b0, 2'd0, 32'h0, 4'b0001, "R5");
        step(1'b0, 2'd0, 32'h0, 4'b0000, "R5");
        // R9: push and pop at the same edge keep one entry.
        step(1'b1, 2'd1, 32'hF0F0_0006, 4'b0000, "R9");
        step(1'b1, 2'd2, 32'h1234_0007, 4'b0010, "R9");
        step(1'b0, 2'd0, 32'h0, 4'b0100, "R9");
        step(1'b0, 2'd0, 32'h0, 4'b0000, "R9");
        // R10: reset in the middle of a run drops both entries.
        step(1'b1, 2'd0, 32'h5555_0008, 4'b0000, "R10");
        step(1'b1, 2'd3, 32'h6666_0009, 4'b0000, "R10");
        do_reset();
        step(1'b0, 2'd0, 32'h0, 4'b0000, "R10");
        // Random mix covering R1..R9 against the model.
        for (int i = 0; i < 3000; i++) begin
            logic pv;
            pv = ($urandom % 10) < 7;
            step(pv, TW'($urandom), $urandom, NC'($urandom), "R1");
        end
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule